// File: doc/BRIEF.md
# Bulk Configuration Register Writer

This block loads a full bank of configuration registers into an external peripheral in a single serial transfer. On a start request it walks the register addresses from 0x11 up to 0x3F in ascending order, one address at a time. It passes over every address that is a multiple of eight, because those select register pages and must not be touched. For each address it keeps, it sends two bytes to a byte-wide serial engine: first an address byte in write format, then the value held for that register. The values come from a local array, which the block reads through a synchronous read port. Slot `k` of that array holds the value for address `0x10 + k`.

The request carries a length. A length above the largest allowed value is refused: the block raises an error flag, pulses done, and sends nothing. An accepted request always sends the whole window. Chip-select stays asserted from the first byte to the last. Done pulses once the serial engine reports that the final byte has left the shifter.

Top module: `regset_burst_writer`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o`, `err_o`, `cs_o`, `tx_valid_o` and `val_rd_o` are all low.
- R2: An accepted request emits exactly 42 address/data pairs (84 bytes), with addresses ascending from 0x11 to 0x3F and every multiple of 8 (0x18, 0x20, 0x28, 0x30, 0x38) left out.
- R3: Each pair is the write-format address byte, followed by the array value for that address. The address byte is `(addr << 1) & 0x7E`: bit 7 is 0, bits 6..1 carry the address, and bit 0 is 0. The value is taken from array slot `addr - 0x10`.
- R4: `val_rd_o` is pulsed only for slots in 0..47 whose address is not a multiple of 8. The read data is taken on the cycle after the strobe. Each transfer issues exactly 42 reads.
- R5: A start with `len_i` greater than 47 is refused. On the next cycle `err_o` is high and `done_o` pulses. No byte is sent, no read is made, and `cs_o` stays low.
- R6: A start with `len_i` from 0 up to 47 inclusive is accepted. The value of the length does not change the bytes sent.
- R7: `cs_o` rises on the cycle after an accepted start. It stays high until `done_o` rises, and it falls in that same cycle. `tx_valid_o` is never high while `cs_o` is low.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` keeps its value on the next cycle.
- R9: `done_o` is a one-cycle pulse. It comes on the cycle after the first cycle in which all bytes have been accepted and `eng_idle_i` is high.
- R10: `err_o` holds its value until the next start taken while idle. An accepted start clears it, and a refused start sets it again.
- R11: A start that arrives while `busy_o` is high is ignored. The transfer in progress, `err_o` and the byte stream are all unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken only while idle |
| len_i | input | LEN_W | Requested length, checked against the limit |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request was refused |
| val_rd_o | output | 1 | Read strobe into the value array |
| val_idx_o | output | IDX_W | Array slot being read |
| val_data_i | input | DATA_W | Array read data, one cycle after the strobe |
| tx_valid_o | output | 1 | Byte offered to the serial engine |
| tx_data_o | output | DATA_W | Byte offered to the serial engine |
| tx_ready_i | input | 1 | Serial engine accepts the byte |
| eng_idle_i | input | 1 | Serial engine has no byte in flight |
| cs_o | output | 1 | Chip-select, held across the whole transfer |

## Verification
Each internal fault shows up at the ports, and most within one cycle:

- **Address walker one step off.** If it skips a page register late or advances twice, the very next address byte differs from the expected sequence.
- **Stale read data.** If the value register holds old data, it appears in the data byte of the same pair.
- **Wrong controller state.**
  - An early exit shows as a short byte count at done, or as `cs_o` falling while bytes are still owed.
  - A controller that never leaves the drain state shows as a missing done pulse on the cycle after the engine goes idle.
- **Error flag.** A wrong flag is visible on the first cycle after the start is sampled, and on every cycle it is held.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_ADDR  = 3'd2,
    ST_DATA  = 3'd3,
    ST_DRAIN = 3'd4
  } rsw_state_e;

  // First address at or above lo that is not a page-select register.
  function automatic int first_kept(input int lo, input int stride);
    return ((lo % stride) == 0) ? lo + 1 : lo;
  endfunction

endpackage

// File: rtl/rsw_addr_walker.sv
module rsw_addr_walker #(
  parameter int WIN_LO      = 16,
  parameter int WIN_HI      = 63,
  parameter int BANK_STRIDE = 8,
  parameter int AW          = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  import rsw_pkg::*;

  localparam int FIRST = first_kept(WIN_LO, BANK_STRIDE);
  localparam bit POW2  = (BANK_STRIDE & (BANK_STRIDE - 1)) == 0;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] cand;
  logic [AW-1:0] nxt;
  logic          cand_bank;

  assign cand = addr_q + AW'(1);

  generate
    if (POW2) begin : g_mask
      localparam int SB = (BANK_STRIDE > 1) ? $clog2(BANK_STRIDE) : 1;
      assign cand_bank = (cand[SB-1:0] == '0);
    end else begin : g_mod
      assign cand_bank = ((int'(cand) % BANK_STRIDE) == 0);
    end
  endgenerate

  assign nxt = cand_bank ? cand + AW'(1) : cand;

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      addr_q <= AW'(FIRST);
    end else if (step_i) begin
      addr_q <= nxt;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (int'(nxt) > WIN_HI);

  // R2: the walker never rests on a page register or outside the window
  a_r2_addr_in_window: assert property (@(posedge clk) disable iff (rst)
    (int'(addr_q) >= WIN_LO) && (int'(addr_q) <= WIN_HI) &&
    ((int'(addr_q) % BANK_STRIDE) != 0));

endmodule

// File: rtl/rsw_len_gate.sv
module rsw_len_gate #(
  parameter int LEN_W   = 8,
  parameter int MAX_LEN = 47
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             ok_o,
  output logic             err_o
);
  logic err_q;

  assign ok_o = ({{(32-LEN_W){1'b0}}, len_i} <= 32'(MAX_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (req_i) begin
      err_q <= !ok_o;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/regset_burst_writer.sv
module regset_burst_writer
  import rsw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 8,
  parameter int WIN_LO      = 16,
  parameter int WIN_HI      = 63,
  parameter int BANK_STRIDE = 8,
  parameter int IDX_W       = $clog2(WIN_HI - WIN_LO + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              val_rd_o,
  output logic [IDX_W-1:0]  val_idx_o,
  input  logic [DATA_W-1:0] val_data_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  input  logic              eng_idle_i,
  output logic              cs_o
);
  localparam int WIN_N   = WIN_HI - WIN_LO + 1;
  localparam int AW      = $clog2(WIN_HI + 3);
  localparam int MAX_LEN = WIN_HI - WIN_LO;

  rsw_state_e        state_q;
  logic              cs_q;
  logic              done_q;
  logic              rd_d;
  logic [DATA_W-1:0] data_q;
  logic [AW-1:0]     addr;
  logic              last;
  logic              len_ok;
  logic              take_req;
  logic              init_walk;
  logic              step_walk;
  logic              hs;
  logic [DATA_W-1:0] addr_byte;

  assign take_req  = (state_q == ST_IDLE) && start_i;
  assign hs        = tx_valid_o && tx_ready_i;
  assign init_walk = take_req && len_ok;
  assign step_walk = (state_q == ST_DATA) && hs && !last;

  rsw_len_gate #(
    .LEN_W  (LEN_W),
    .MAX_LEN(MAX_LEN)
  ) u_len (
    .clk  (clk),
    .rst  (rst),
    .req_i(take_req),
    .len_i(len_i),
    .ok_o (len_ok),
    .err_o(err_o)
  );

  rsw_addr_walker #(
    .WIN_LO     (WIN_LO),
    .WIN_HI     (WIN_HI),
    .BANK_STRIDE(BANK_STRIDE),
    .AW         (AW)
  ) u_walk (
    .clk   (clk),
    .rst   (rst),
    .init_i(init_walk),
    .step_i(step_walk),
    .addr_o(addr),
    .last_o(last)
  );

  // Write-format address byte: top bit clear, address shifted up one.
  assign addr_byte = (DATA_W'(addr) << 1) & ~(DATA_W'(1) << (DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (len_ok) begin
              state_q <= ST_FETCH;
              cs_q    <= 1'b1;
            end else begin
              done_q  <= 1'b1;
            end
          end
        end
        ST_FETCH: state_q <= ST_ADDR;
        ST_ADDR: begin
          if (tx_ready_i) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (tx_ready_i) state_q <= last ? ST_DRAIN : ST_FETCH;
        end
        ST_DRAIN: begin
          if (eng_idle_i) begin
            state_q <= ST_IDLE;
            cs_q    <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Array read: data appears one cycle after the strobe; captured then.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d   <= 1'b0;
      data_q <= '0;
    end else begin
      rd_d <= (state_q == ST_FETCH);
      if (rd_d) data_q <= val_data_i;
    end
  end

  assign val_rd_o   = (state_q == ST_FETCH);
  assign val_idx_o  = IDX_W'(int'(addr) - WIN_LO);
  assign tx_valid_o = (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign tx_data_o  = (state_q == ST_ADDR) ? addr_byte : data_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign cs_o       = cs_q;

  // R8: an offered byte is held until taken
  a_r8_hold_byte: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R7: bytes only go out under chip-select
  a_r7_valid_under_cs: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> cs_o);

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: a refused request never drives chip-select
  a_r5_err_no_cs: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !cs_o);

  // R4: reads stay inside the value array
  a_r4_read_in_range: assert property (@(posedge clk) disable iff (rst)
    val_rd_o |-> (int'(val_idx_o) < WIN_N));

  // R11: while a transfer runs the error flag stays clear
  a_r11_busy_no_err: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !err_o);

endmodule

// File: tb/regset_burst_writer_tb.sv
module regset_burst_writer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] len_i = '0;
  logic       busy_o, done_o, err_o, val_rd_o, tx_valid_o, cs_o;
  logic [5:0] val_idx_o;
  logic [7:0] val_data_i;
  logic [7:0] tx_data_o;
  logic       tx_ready_i, eng_idle_i;

  always #5 clk = ~clk;

  regset_burst_writer dut_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .len_i     (len_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .val_rd_o  (val_rd_o),
    .val_idx_o (val_idx_o),
    .val_data_i(val_data_i),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o),
    .tx_ready_i(tx_ready_i),
    .eng_idle_i(eng_idle_i),
    .cs_o      (cs_o)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Value array with one-cycle read latency
  logic [7:0] mem [0:47];
  always @(posedge clk) if (val_rd_o) val_data_i <= mem[val_idx_o];

  // Serial engine model
  int         shift_len = 1;
  bit         stall_en  = 1'b0;
  int         eng_cnt   = 0;
  logic [7:0] lfsr      = 8'hA5;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rst) eng_cnt <= 0;
    else if (tx_valid_o && tx_ready_i) eng_cnt <= shift_len;
    else if (eng_cnt > 0) eng_cnt <= eng_cnt - 1;
  end
  assign eng_idle_i = (eng_cnt == 0);
  assign tx_ready_i = (eng_cnt == 0) && !(stall_en && lfsr[0]);

  // Behavioural reference, compared every cycle
  logic [7:0] exp_q[$];
  bit   m_active = 0, m_err = 0, exp_done = 0, hold_pend = 0;
  logic [7:0] hold_byte;
  int   byte_cnt = 0, rd_cnt = 0;

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      bit pre_empty, next_done;
      chk(done_o === exp_done, "R9 done", done_o, exp_done);
      chk(err_o === m_err, "R10 err", err_o, m_err);
      chk(cs_o === m_active, "R7 cs", cs_o, m_active);
      chk(busy_o === m_active, "R11 busy", busy_o, m_active);
      if (tx_valid_o) chk(cs_o === 1'b1, "R7 valid under cs", cs_o, 1);
      if (hold_pend)
        chk(tx_valid_o && tx_data_o == hold_byte, "R8 hold", tx_data_o, hold_byte);
      if (val_rd_o) begin
        chk(m_active, "R5 read only when accepted", 0, 1);
        chk(val_idx_o < 48 && ((val_idx_o + 16) % 8) != 0, "R4 read slot", val_idx_o, -1);
        rd_cnt++;
      end
      pre_empty = (exp_q.size() == 0);
      hold_pend = tx_valid_o && !tx_ready_i;
      hold_byte = tx_data_o;
      if (tx_valid_o && tx_ready_i) begin
        byte_cnt++;
        if (exp_q.size() == 0) chk(0, "R2 extra byte", tx_data_o, -1);
        else begin
          logic [7:0] eb;
          eb = exp_q.pop_front();
          chk(tx_data_o == eb, "R3 byte", tx_data_o, eb);
        end
      end
      next_done = 0;
      if (m_active && pre_empty && eng_idle_i) begin
        next_done = 1;
        m_active  = 0;
        chk(byte_cnt == 84, "R2 byte count", byte_cnt, 84);
        chk(rd_cnt == 42, "R4 read count", rd_cnt, 42);
      end else if (!m_active && start_i) begin
        if (len_i > 47) begin
          m_err = 1;
          next_done = 1;
        end else begin
          m_err = 0;
          m_active = 1;
          byte_cnt = 0;
          rd_cnt = 0;
          for (int a = 16; a <= 63; a++) begin
            if (a % 8 != 0) begin
              exp_q.push_back(8'((a * 2) & 8'h7E));
              exp_q.push_back(mem[a - 16]);
            end
          end
        end
      end
      exp_done = next_done;
    end
  end

  task automatic req(input int len);
    @(negedge clk);
    start_i = 1'b1;
    len_i   = 8'(len);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 48; i++) mem[i] = 8'((i * seed + 3) ^ (i << 2));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    fill(7);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1: reset state
    chk(!busy_o && !done_o && !err_o && !cs_o && !tx_valid_o && !val_rd_o,
        "R1 reset outputs", {busy_o, done_o, err_o, cs_o, tx_valid_o}, 0);

    // R2 R3: plain run, short shifts
    shift_len = 1; stall_en = 0;
    req(5);
    chk(busy_o === 1'b1, "R6 len 5 accepted", busy_o, 1);
    wait_idle();

    // R6: length 0 with stalls and longer shifts (R8)
    fill(13); shift_len = 3; stall_en = 1;
    req(0);
    chk(busy_o === 1'b1, "R6 len 0 accepted", busy_o, 1);
    wait_idle();

    // R6: boundary 47 accepted
    fill(29); shift_len = 2; stall_en = 0;
    req(47);
    chk(busy_o === 1'b1, "R6 len 47 accepted", busy_o, 1);
    wait_idle();

    // R5: 48 refused, error held (R10)
    req(48);
    #1;
    chk(err_o === 1'b1 && !cs_o && !tx_valid_o, "R5 refuse 48", err_o, 1);
    repeat (6) @(negedge clk);
    #1;
    chk(err_o === 1'b1, "R10 err held", err_o, 1);
    req(200);
    #1;
    chk(err_o === 1'b1 && !busy_o, "R5 refuse 200", err_o, 1);
    // R10: accepted start clears the flag
    fill(3); shift_len = 1; stall_en = 1;
    req(10);
    #1;
    chk(err_o === 1'b0, "R10 cleared by accepted start", err_o, 0);

    // R11: start while busy is ignored
    repeat (10) @(negedge clk);
    req(100);
    #1;
    chk(err_o === 1'b0 && busy_o === 1'b1, "R11 start ignored while busy", err_o, 0);
    wait_idle();
    chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule